// File: doc/BRIEF.md
# Out-of-Order Reservation-Station Scheduler

This block accepts an in-order stream of floating-point style instructions, one per cycle, and places each into a free station of its class. There are load buffers, add/subtract stations and multiply/divide stations. As it enters, each source register is renamed. The station stores the register's value if no instruction is still going to write it. Otherwise it stores the tag of the station that will produce that value. Each station runs a latency countdown once both of its operands are present. The countdown length depends on the operation.

A finished result goes out on a single result bus one cycle after its execution ends. In that same cycle, every waiting station and the register file take the value. The arithmetic is a stand-in: simple integer functions replace real floating-point results. A load returns the data word that came with the instruction, after a fixed latency. Issue is in program order, while execution and completion are out of order.

Top module: `tomasulo_sched`

## Requirements
- R1: After reset, register r holds the value r+1, no register has a pending tag, no result is broadcast and every station is free (in_ready is high for any legal operation).
- R2: Operation codes are 0 load, 1 add, 2 subtract, 3 multiply, 4 divide. in_ready is high exactly when a station of the operation's class is free: load buffers are tags 1-3, add/subtract stations tags 4-6, multiply/divide stations tags 7-8, and tag 0 means "no producer". Codes 5-7 are never accepted. An instruction is accepted on a clock edge with in_valid and in_ready both high, into the lowest free station of its class.
- R3: Each source operand is captured at acceptance in one of three ways. If the register has no pending tag, the register value is used. If its pending tag is being broadcast in that cycle, the broadcast value is used. Otherwise the pending tag is stored.
- R4: A station's countdown starts in the first cycle in which it holds both operands, and not before. The countdown is 1 cycle for a load, 2 for add or subtract, 10 for multiply and 40 for divide. The result is broadcast in the cycle after the countdown ends.
- R5: The broadcast value is the load's data word for a load, a+b for add, a-b for subtract, the low 16 bits of a*b for multiply, and a XOR b for divide (first operand rs, second rt; all modulo 2^16).
- R6: At most one result is broadcast per cycle. Among finished stations, the lowest tag wins, so loads come before add/subtract and those come before multiply/divide. The other finished stations hold their results and retry in the next cycle.
- R7: In the broadcast cycle, every station waiting on the broadcast tag stores the value and clears that tag.
- R8: A register whose pending tag matches the broadcast takes the value and clears its tag. An accepted instruction sets its destination's tag in the same edge and overrides that clear, so the newest writer wins and an older result never overwrites it.
- R9: A station becomes free at the end of its broadcast cycle and can accept an instruction in the following cycle.
- R10: An instruction that has captured a register value keeps that value even after a later instruction renames the same register.
- R11: Several loads may be in flight at once, and a later short instruction may broadcast before an earlier long one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_op | input | 3 | Operation code |
| in_rd | input | clog2(NREG) | Destination register |
| in_rs | input | clog2(NREG) | First source register |
| in_rt | input | clog2(NREG) | Second source register |
| in_ldata | input | DW | Data returned by a load |
| in_ready | output | 1 | A station of the instruction's class is free |
| cdb_valid | output | 1 | Result bus carries a result |
| cdb_tag | output | clog2(NLD+NADD+NMUL+1) | Producer tag of the result |
| cdb_data | output | DW | Result value |
| rf_addr | input | clog2(NREG) | Register observation address |
| rf_data | output | DW | Value of the addressed register |
| rf_tag | output | clog2(NLD+NADD+NMUL+1) | Pending tag of the addressed register |

## Verification
The bench builds the block with its default parameters: 8 registers, 16-bit data, 3/3/2 stations and latencies of 1, 2, 10 and 40 cycles. With the full 40-cycle divide and only two multiply/divide stations, a short stream is enough to stall issue behind a full class. The same setup lets a later add finish long before an earlier multiply, and makes a load and an add finish in the same cycle so they contend for the bus. Together these cover the stall, out-of-order completion and bus contention cases.

// File: rtl/tomasulo_sched.sv
module tomasulo_sched #(
  parameter int NREG    = 8,
  parameter int DW      = 16,
  parameter int NLD     = 3,
  parameter int NADD    = 3,
  parameter int NMUL    = 2,
  parameter int LAT_LD  = 1,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 40,
  localparam int RW  = $clog2(NREG),
  localparam int NST = NLD + NADD + NMUL,
  localparam int TW  = $clog2(NST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    in_op,
  input  logic [RW-1:0] in_rd,
  input  logic [RW-1:0] in_rs,
  input  logic [RW-1:0] in_rt,
  input  logic [DW-1:0] in_ldata,
  output logic          in_ready,
  output logic          cdb_valid,
  output logic [TW-1:0] cdb_tag,
  output logic [DW-1:0] cdb_data,
  input  logic [RW-1:0] rf_addr,
  output logic [DW-1:0] rf_data,
  output logic [TW-1:0] rf_tag
);
  localparam int SW = $clog2(NST);
  localparam int M1 = (LAT_LD > LAT_ADD) ? LAT_LD : LAT_ADD;
  localparam int M2 = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV;
  localparam int LMAX = (M1 > M2) ? M1 : M2;
  localparam int CW = $clog2(LMAX + 1);
  localparam logic [2:0] OP_LD = 3'd0, OP_ADD = 3'd1, OP_SUB = 3'd2, OP_MUL = 3'd3, OP_DIV = 3'd4;

  logic [NST-1:0] busy, fin;
  logic [2:0]     sop [NST];
  logic [DW-1:0]  vj [NST], vk [NST];
  logic [TW-1:0]  qj [NST], qk [NST];
  logic [CW-1:0]  cnt [NST];
  logic [DW-1:0]  rf [NREG];
  logic [TW-1:0]  stat [NREG];

  logic [SW-1:0]  slot, win;
  logic           found, issue;
  logic [DW-1:0]  jv, kv;
  logic [TW-1:0]  jq, kq;
  int lo, hi;

  function automatic logic [CW-1:0] lat_of(input logic [2:0] op);
    case (op)
      OP_LD:          return CW'(LAT_LD);
      OP_ADD, OP_SUB: return CW'(LAT_ADD);
      OP_MUL:         return CW'(LAT_MUL);
      default:        return CW'(LAT_DIV);
    endcase
  endfunction

  always_comb begin
    case (in_op)
      OP_LD:          begin lo = 0;          hi = NLD;        end
      OP_ADD, OP_SUB: begin lo = NLD;        hi = NLD + NADD; end
      OP_MUL, OP_DIV: begin lo = NLD + NADD; hi = NST;        end
      default:        begin lo = 0;          hi = 0;          end
    endcase
    found = 1'b0;
    slot  = '0;
    for (int s = NST - 1; s >= 0; s--)
      if (s >= lo && s < hi && !busy[s]) begin found = 1'b1; slot = SW'(s); end
  end

  assign in_ready = found;
  assign issue    = in_valid && found;

  genvar g;
  generate
    for (g = 0; g < NST; g++) begin : g_fin
      assign fin[g] = busy[g] && qj[g] == '0 && qk[g] == '0 && cnt[g] == '0;
    end
  endgenerate

  always_comb begin
    win = '0;
    for (int s = NST - 1; s >= 0; s--) if (fin[s]) win = SW'(s);
  end

  assign cdb_valid = |fin;
  assign cdb_tag   = cdb_valid ? TW'(win) + TW'(1) : '0;

  always_comb
    case (sop[win])
      OP_LD:   cdb_data = vj[win];
      OP_ADD:  cdb_data = vj[win] + vk[win];
      OP_SUB:  cdb_data = vj[win] - vk[win];
      OP_MUL:  cdb_data = vj[win] * vk[win];
      default: cdb_data = vj[win] ^ vk[win];
    endcase

  always_comb begin
    if (stat[in_rs] == '0)                            begin jv = rf[in_rs]; jq = '0; end
    else if (cdb_valid && stat[in_rs] == cdb_tag)     begin jv = cdb_data;  jq = '0; end
    else                                              begin jv = '0; jq = stat[in_rs]; end
    if (stat[in_rt] == '0)                            begin kv = rf[in_rt]; kq = '0; end
    else if (cdb_valid && stat[in_rt] == cdb_tag)     begin kv = cdb_data;  kq = '0; end
    else                                              begin kv = '0; kq = stat[in_rt]; end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0;
      for (int s = 0; s < NST; s++) begin
        sop[s] <= OP_LD; vj[s] <= '0; vk[s] <= '0;
        qj[s] <= '0; qk[s] <= '0; cnt[s] <= '0;
      end
    end else begin
      for (int s = 0; s < NST; s++) begin
        if (issue && slot == SW'(s)) begin
          busy[s] <= 1'b1;
          sop[s]  <= in_op;
          cnt[s]  <= lat_of(in_op);
          if (in_op == OP_LD) begin
            vj[s] <= in_ldata; vk[s] <= '0; qj[s] <= '0; qk[s] <= '0;
          end else begin
            vj[s] <= jv; vk[s] <= kv; qj[s] <= jq; qk[s] <= kq;
          end
        end else if (cdb_valid && win == SW'(s)) begin
          busy[s] <= 1'b0;
        end else if (busy[s]) begin
          if (qj[s] == '0 && qk[s] == '0 && cnt[s] != '0) cnt[s] <= cnt[s] - CW'(1);
          if (cdb_valid && qj[s] == cdb_tag) begin vj[s] <= cdb_data; qj[s] <= '0; end
          if (cdb_valid && qk[s] == cdb_tag) begin vk[s] <= cdb_data; qk[s] <= '0; end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin rf[r] <= DW'(r + 1); stat[r] <= '0; end
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (cdb_valid && stat[r] == cdb_tag) begin rf[r] <= cdb_data; stat[r] <= '0; end
        if (issue && in_rd == RW'(r)) stat[r] <= TW'(slot) + TW'(1);
      end
    end
  end

  assign rf_data = rf[rf_addr];
  assign rf_tag  = stat[rf_addr];

  assert_newest_writer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> stat[$past(in_rd)] == TW'($past(slot)) + TW'(1));

  assert_free_after_bcast_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid |=> !busy[$past(win)]);

  assert_load_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cdb_valid && |fin[NLD-1:0]) |-> cdb_tag <= TW'(NLD));

  generate
    for (g = 0; g < NST; g++) begin : g_chk
      assert_timer_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy[g] && (qj[g] != '0 || qk[g] != '0)) |=> cnt[g] == $past(cnt[g]));
      assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy[g] && cdb_valid && qj[g] == cdb_tag && win != SW'(g)) |=> (qj[g] == '0 && vj[g] == $past(cdb_data)));
    end
  endgenerate
endmodule

// File: tb/tomasulo_sched_bench.sv
`timescale 1ns/1ps
module tomasulo_sched_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] in_op = '0;
  logic [2:0] in_rd = '0, in_rs = '0, in_rt = '0, rf_addr = '0;
  logic [15:0] in_ldata = '0;
  logic in_ready, cdb_valid;
  logic [3:0] cdb_tag, rf_tag;
  logic [15:0] cdb_data, rf_data;

  always #2 clk = ~clk;

  tomasulo_sched #(.NREG(8), .DW(16), .NLD(3), .NADD(3), .NMUL(2),
                   .LAT_LD(1), .LAT_ADD(2), .LAT_MUL(10), .LAT_DIV(40)) u_tomasulo_sched (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_rd(in_rd),
    .in_rs(in_rs), .in_rt(in_rt), .in_ldata(in_ldata), .in_ready(in_ready),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .rf_addr(rf_addr), .rf_data(rf_data), .rf_tag(rf_tag));

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  int m_busy[8], m_op[8], m_vj[8], m_vk[8], m_qj[8], m_qk[8], m_cnt[8];
  int m_rf[8], m_st[8];
  int lg_c[$], lg_t[$], lg_d[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int lat(input int op);
    case (op) 0: return 1; 1, 2: return 2; 3: return 10; default: return 40; endcase
  endfunction

  function automatic int res(input int op, input int a, input int b);
    longint p;
    case (op)
      0: return a;
      1: return (a + b) & 16'hFFFF;
      2: return (a - b) & 16'hFFFF;
      3: begin p = longint'(a) * longint'(b); return int'(p & 64'hFFFF); end
      default: return a ^ b;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    for (int s = 0; s < 8; s++) begin
      m_busy[s] = 0; m_op[s] = 0; m_vj[s] = 0; m_vk[s] = 0; m_qj[s] = 0; m_qk[s] = 0; m_cnt[s] = 0;
    end
    for (int r = 0; r < 8; r++) begin m_rf[r] = r + 1; m_st[r] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    lg_c.delete(); lg_t.delete(); lg_d.delete();
  endtask

  task automatic cycle_do(input bit v, input int op, input int rd, input int rs, input int rt,
                          input int ld, output bit acc);
    int lo, hi, slot, w, wtag, wdata, sv0, sq0, sv1, sq1;
    @(negedge clk);
    in_valid = v; in_op = op[2:0]; in_rd = rd[2:0]; in_rs = rs[2:0]; in_rt = rt[2:0];
    in_ldata = ld[15:0]; rf_addr = cyc[2:0];
    #1;
    if (op == 0) begin lo = 0; hi = 3; end
    else if (op <= 2) begin lo = 3; hi = 6; end
    else if (op <= 4) begin lo = 6; hi = 8; end
    else begin lo = 0; hi = 0; end
    slot = -1;
    for (int s = 0; s < 8; s++) if (s >= lo && s < hi && !m_busy[s] && slot < 0) slot = s;
    w = -1;
    for (int s = 0; s < 8; s++)
      if (w < 0 && m_busy[s] && m_qj[s] == 0 && m_qk[s] == 0 && m_cnt[s] == 0) w = s;
    wtag = w + 1;
    wdata = (w >= 0) ? res(m_op[w], m_vj[w], m_vk[w]) : 0;

    chk(in_ready == (slot >= 0), "R2", "in_ready", in_ready, slot >= 0);
    chk(cdb_valid == (w >= 0), "R4", "cdb_valid", cdb_valid, w >= 0);
    if (w >= 0 && cdb_valid) begin
      chk(cdb_tag == wtag, "R6", "cdb_tag", cdb_tag, wtag);
      chk(cdb_data == wdata, "R5", "cdb_data", cdb_data, wdata);
    end
    chk(rf_data == m_rf[cyc % 8], "R8", "rf_data", rf_data, m_rf[cyc % 8]);
    chk(rf_tag == m_st[cyc % 8], "R8", "rf_tag", rf_tag, m_st[cyc % 8]);
    if (cdb_valid) begin lg_c.push_back(cyc); lg_t.push_back(cdb_tag); lg_d.push_back(cdb_data); end

    if (m_st[rs] == 0) begin sv0 = m_rf[rs]; sq0 = 0; end
    else if (wtag != 0 && m_st[rs] == wtag) begin sv0 = wdata; sq0 = 0; end
    else begin sv0 = 0; sq0 = m_st[rs]; end
    if (m_st[rt] == 0) begin sv1 = m_rf[rt]; sq1 = 0; end
    else if (wtag != 0 && m_st[rt] == wtag) begin sv1 = wdata; sq1 = 0; end
    else begin sv1 = 0; sq1 = m_st[rt]; end

    for (int s = 0; s < 8; s++)
      if (m_busy[s] && m_qj[s] == 0 && m_qk[s] == 0 && m_cnt[s] > 0) m_cnt[s]--;
    if (w >= 0) begin
      for (int s = 0; s < 8; s++) if (m_busy[s]) begin
        if (m_qj[s] == wtag) begin m_vj[s] = wdata; m_qj[s] = 0; end
        if (m_qk[s] == wtag) begin m_vk[s] = wdata; m_qk[s] = 0; end
      end
      m_busy[w] = 0;
      for (int r = 0; r < 8; r++) if (m_st[r] == wtag) begin m_rf[r] = wdata; m_st[r] = 0; end
    end
    acc = v && slot >= 0;
    if (acc) begin
      m_busy[slot] = 1; m_op[slot] = op; m_cnt[slot] = lat(op);
      if (op == 0) begin m_vj[slot] = ld; m_vk[slot] = 0; m_qj[slot] = 0; m_qk[slot] = 0; end
      else begin m_vj[slot] = sv0; m_qj[slot] = sq0; m_vk[slot] = sv1; m_qk[slot] = sq1; end
      m_st[rd] = slot + 1;
    end
    cyc++;
  endtask

  task automatic issue_one(input int op, input int rd, input int rs, input int rt, input int ld,
                           output int when);
    bit acc = 0;
    while (!acc) begin when = cyc; cycle_do(1, op, rd, rs, rt, ld, acc); end
  endtask

  task automatic idle(input int n);
    bit acc;
    repeat (n) cycle_do(0, 0, 0, 0, 0, 0, acc);
  endtask

  task automatic peek(input int a, input int expv, input int expt, input string req);
    @(negedge clk);
    in_valid = 1'b0; rf_addr = a[2:0];
    #1;
    chk(rf_data == expv, req, "register value", rf_data, expv);
    chk(rf_tag == expt, req, "register tag", rf_tag, expt);
  endtask

  task automatic expect_at(input int tag, input int c, input int d, input string req);
    int k = -1;
    foreach (lg_t[i]) if (k < 0 && lg_t[i] == tag) k = i;
    chk(k >= 0, req, "broadcast seen for tag", tag, tag);
    if (k >= 0) begin
      if (c >= 0) chk(lg_c[k] == c, req, "broadcast cycle", lg_c[k], c);
      if (d >= 0) chk(lg_d[k] == d, req, "broadcast value", lg_d[k], d);
    end
  endtask

  initial begin
    int t;
    do_reset();
    // R1 reset state
    #1;
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(cdb_valid == 1'b0, "R1", "cdb_valid after reset", cdb_valid, 0);
    for (int r = 0; r < 8; r++) peek(r, r + 1, 0, "R1");

    // Scenario A: dependent chain with renaming
    do_reset();
    issue_one(0, 6, 0, 0, 100, t);
    issue_one(0, 2, 0, 0, 7, t);
    issue_one(3, 0, 2, 4, 0, t);
    issue_one(2, 5, 6, 2, 0, t);
    issue_one(4, 3, 0, 6, 0, t);
    issue_one(1, 6, 5, 2, 0, t);
    idle(60);
    expect_at(1, 2, 100, "R11");
    expect_at(2, 3, 7, "R11");
    expect_at(4, 6, 93, "R3");
    expect_at(4, 6, -1, "R4");
    expect_at(5, 9, 100, "R5");
    expect_at(7, 14, 35, "R7");
    expect_at(7, 14, -1, "R4");
    expect_at(8, 55, 71, "R10");
    expect_at(8, 55, -1, "R4");
    peek(6, 100, 0, "R8");
    peek(3, 71, 0, "R10");

    // Scenario B: full multiply class stalls, freed slot reused
    do_reset();
    issue_one(3, 1, 2, 3, 0, t);
    issue_one(3, 4, 2, 3, 0, t);
    issue_one(3, 7, 2, 2, 0, t);
    chk(t == 12, "R9", "stalled multiply accepted in cycle", t, 12);
    idle(20);
    expect_at(7, 11, 12, "R9");
    expect_at(8, 12, 12, "R2");

    // Scenario C: load beats add on the bus; newest writer keeps register
    do_reset();
    issue_one(3, 1, 2, 3, 0, t);
    issue_one(1, 1, 2, 3, 0, t);
    issue_one(0, 5, 0, 0, 9, t);
    idle(15);
    expect_at(1, 4, 9, "R6");
    expect_at(4, 5, 7, "R6");
    expect_at(7, 11, 12, "R11");
    peek(1, 7, 0, "R8");
    peek(5, 9, 0, "R8");

    // Random stream checked cycle by cycle against the model
    do_reset();
    for (int i = 0; i < 300; i++) begin
      bit acc;
      if ($urandom_range(0, 4) == 0) idle(1);
      issue_one($urandom_range(0, 4), $urandom_range(0, 7), $urandom_range(0, 7),
                $urandom_range(0, 7), $urandom_range(0, 65535), t);
    end
    idle(120);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule